// File: doc/BRIEF.md
# Miss Line Buffer with Qualified Forwarding

This block sits beside a level-one data cache and tracks the cache lines that are outstanding after a load miss. Each of its entries holds one 64-byte line, that line's physical address and the ID of the logical core that asked for it. A load that misses the cache and finds no entry for its line takes the lowest-numbered free entry. The block then sends a line request to memory. When the fill returns, the entry stores the line. In that same cycle the block writes the line to the cache array and hands the waiting load its bytes.

A filled entry stays readable for a fixed number of cycles. During that window, later misses from the same core to the same line are served from the entry. After the window the entry frees, and only its state bit changes. Forwarding is qualified: a match needs a live entry, an equal line address and an equal core ID. A load flagged as faulting always gets zero data. Any response that reports failure carries zero data, so stale contents of freed entries cannot reach a load.

The load lookup runs in the same cycle as the cache-hit indication. The load response is registered and appears one cycle after the request. Three paths are combinational: the stall signal, the cache-array write and the fill-forward output.

Top module: `miss_line_buf`

## Requirements
- R1: While reset is asserted and right after it: rsp_valid_o, stall_o, mreq_valid_o, cwr_valid_o and fwd_valid_o are 0, and every entry is free.
- R2: A load with ld_fault_i=1 gets a response one cycle later with rsp_ok_o=0 and rsp_data_o=0. This holds whether the cache hits or a live entry matches. The load allocates no entry, raises no memory request and does not stall.
- R3: A non-faulting load with cache_hit_i=1 gets rsp_ok_o=1 one cycle later. Its bytes are taken from cache_line_i (byte k is bits 8k+7:8k). It allocates no entry.
- R4: A non-faulting load that misses the cache and matches no entry, while some entry is free, allocates the lowest-numbered free entry. One cycle later mreq_valid_o=1, with mreq_id_o set to that entry and mreq_la_o set to ld_pa_i[PA_W-1:6], and the response has rsp_ok_o=0.
- R5: A live entry matches a load only if the line address and the core ID are both equal. A miss that matches a pending entry responds with rsp_ok_o=0 and allocates nothing. A miss that matches a filled entry responds with rsp_ok_o=1 and takes its bytes from that entry's line.
- R6: A fill with fill_valid_i=1 that names a pending entry does four things in the same cycle: cwr_valid_o=1, cwr_la_o is the entry's line address, cwr_line_o=fill_line_i, and fwd_valid_o=1. On that fwd_valid_o, fwd_core_o carries the entry's core and fwd_data_o carries the bytes the allocating load asked for. A fill that names a non-pending entry is ignored.
- R7: Byte selection works as follows. The offset is address bits 5:0 and the byte count is 1, 2, 4 or 8 for ld_size_i codes 0, 1, 2 and 3. Result byte k is line byte offset+k when k is below the count and offset+k is below 64. Every other result byte is 0.
- R8: A filled entry stays live for HOLD_CYC cycles after the fill edge and then frees. After that, a same-core miss to the same line is not served and allocates a new entry.
- R9: When every entry is live and a non-faulting miss matches none of them, stall_o is 1 in the same cycle. The response is rsp_ok_o=0, nothing is allocated and no memory request is made.
- R10: Whenever rsp_valid_o=1 and rsp_ok_o=0, rsp_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load lookup this cycle |
| ld_pa_i | input | PA_W | Load physical address |
| ld_size_i | input | 2 | Load size code (1, 2, 4, 8 bytes) |
| ld_core_i | input | CORE_W | Logical core of the load |
| ld_fault_i | input | 1 | Load faults or needs an assist |
| cache_hit_i | input | 1 | Cache array hit for this load |
| cache_line_i | input | 512 | Line read from the cache array |
| stall_o | output | 1 | Miss refused, all entries live |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_ok_o | output | 1 | Response carries valid data |
| rsp_data_o | output | 64 | Response bytes, zero unless ok |
| mreq_valid_o | output | 1 | Line request to memory |
| mreq_id_o | output | ID_W | Entry that owns the request |
| mreq_la_o | output | PA_W-6 | Requested line address |
| fill_valid_i | input | 1 | Fill data returning |
| fill_id_i | input | ID_W | Entry the fill belongs to |
| fill_line_i | input | 512 | Returned line |
| cwr_valid_o | output | 1 | Write line into cache array |
| cwr_la_o | output | PA_W-6 | Line address of the cache write |
| cwr_line_o | output | 512 | Line data of the cache write |
| fwd_valid_o | output | 1 | Fill forward to waiting load |
| fwd_core_o | output | CORE_W | Core of the waiting load |
| fwd_data_o | output | 64 | Forwarded bytes |

## Verification
A corrupted entry state shows up at the ports within one cycle of the next load to that line, or within one cycle of the next fill to that entry. A pending entry that looks free raises a duplicate mreq_valid_o. A freed entry that still looks live raises rsp_ok_o where a miss was due. A wrong address, core or byte offset kept in an entry is visible only when that entry is filled or forwarded from, through cwr_la_o, fwd_core_o or the forwarded bytes. The bench therefore fills every entry it allocates, and then reads from the filled entries both inside and after the retention window.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  localparam int LINE_BYTES = 64;
  localparam int OFF_W      = 6;
  localparam int RSP_BYTES  = 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int RSP_W      = RSP_BYTES * 8;

  typedef enum logic [1:0] {ST_FREE, ST_PEND, ST_FULL} ent_st_e;

  function automatic logic [RSP_W-1:0] pick_bytes(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [1:0] sz);
    logic [RSP_W-1:0] res;
    int nb;
    res = '0;
    nb  = 1 << sz;
    for (int k = 0; k < RSP_BYTES; k++) begin
      if (k < nb && (int'(off) + k) < LINE_BYTES)
        res[8*k +: 8] = line[8*(int'(off) + k) +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/mlb_byte_sel.sv
module mlb_byte_sel
  import mlb_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        sz_i,
  output logic [RSP_W-1:0]  data_o
);
  always_comb data_o = pick_bytes(line_i, off_i, sz_i);
endmodule

// File: rtl/mlb_entry.sv
module mlb_entry
  import mlb_pkg::*;
#(
  parameter int LA_W     = 26,
  parameter int CORE_W   = 1,
  parameter int HOLD_CYC = 4,
  localparam int CNT_W   = $clog2(HOLD_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LA_W-1:0]   la_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        sz_i,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              busy_o,
  output logic              pend_o,
  output logic              full_o,
  output logic [LA_W-1:0]   la_o,
  output logic [CORE_W-1:0] core_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [1:0]        sz_o,
  output logic [LINE_W-1:0] line_o
);
  ent_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FREE;
      cnt_q  <= '0;
      la_o   <= '0;
      core_o <= '0;
      off_o  <= '0;
      sz_o   <= '0;
      line_o <= '0;
    end else begin
      unique case (st_q)
        ST_FREE: if (alloc_i) begin
          st_q   <= ST_PEND;
          la_o   <= la_i;
          core_o <= core_i;
          off_o  <= off_i;
          sz_o   <= sz_i;
        end
        ST_PEND: if (fill_i) begin
          st_q   <= ST_FULL;
          line_o <= fill_line_i;
          cnt_q  <= CNT_W'(HOLD_CYC);
        end
        ST_FULL: begin
          // free clears state only; fields keep old contents
          if (cnt_q == CNT_W'(1)) st_q <= ST_FREE;
          else                    cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_FREE);
  assign pend_o = (st_q == ST_PEND);
  assign full_o = (st_q == ST_FULL);
endmodule

// File: rtl/mlb_lookup.sv
module mlb_lookup #(
  parameter int N_ENT  = 4,
  parameter int LA_W   = 26,
  parameter int CORE_W = 1,
  localparam int ID_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0]  busy_i,
  input  logic [N_ENT-1:0]  full_i,
  input  logic [LA_W-1:0]   la_i   [N_ENT],
  input  logic [CORE_W-1:0] core_i [N_ENT],
  input  logic [LA_W-1:0]   q_la_i,
  input  logic [CORE_W-1:0] q_core_i,
  output logic              hit_any_o,
  output logic              hit_full_o,
  output logic [ID_W-1:0]   hit_id_o,
  output logic              free_any_o,
  output logic [ID_W-1:0]   free_id_o
);
  // descending scan so the lowest index wins
  always_comb begin
    hit_any_o  = 1'b0;
    hit_full_o = 1'b0;
    hit_id_o   = '0;
    free_any_o = 1'b0;
    free_id_o  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (busy_i[i] && la_i[i] == q_la_i && core_i[i] == q_core_i) begin
        hit_any_o  = 1'b1;
        hit_full_o = full_i[i];
        hit_id_o   = ID_W'(i);
      end
      if (!busy_i[i]) begin
        free_any_o = 1'b1;
        free_id_o  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/miss_line_buf.sv
module miss_line_buf
  import mlb_pkg::*;
#(
  parameter int N_ENT    = 4,
  parameter int PA_W     = 32,
  parameter int CORE_W   = 1,
  parameter int HOLD_CYC = 4,
  localparam int ID_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int LA_W    = PA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [PA_W-1:0]   ld_pa_i,
  input  logic [1:0]        ld_size_i,
  input  logic [CORE_W-1:0] ld_core_i,
  input  logic              ld_fault_i,
  input  logic              cache_hit_i,
  input  logic [LINE_W-1:0] cache_line_i,
  output logic              stall_o,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic [RSP_W-1:0]  rsp_data_o,
  output logic              mreq_valid_o,
  output logic [ID_W-1:0]   mreq_id_o,
  output logic [LA_W-1:0]   mreq_la_o,
  input  logic              fill_valid_i,
  input  logic [ID_W-1:0]   fill_id_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              cwr_valid_o,
  output logic [LA_W-1:0]   cwr_la_o,
  output logic [LINE_W-1:0] cwr_line_o,
  output logic              fwd_valid_o,
  output logic [CORE_W-1:0] fwd_core_o,
  output logic [RSP_W-1:0]  fwd_data_o
);
  logic [N_ENT-1:0]  e_busy, e_pend, e_full;
  logic [LA_W-1:0]   e_la   [N_ENT];
  logic [CORE_W-1:0] e_core [N_ENT];
  logic [OFF_W-1:0]  e_off  [N_ENT];
  logic [1:0]        e_sz   [N_ENT];
  logic [LINE_W-1:0] e_line [N_ENT];

  logic [LA_W-1:0]   q_la;
  logic [OFF_W-1:0]  q_off;
  logic              hit_any, hit_full, free_any;
  logic [ID_W-1:0]   hit_id, free_id;
  logic              is_miss, do_alloc, ld_ok;

  assign q_la  = ld_pa_i[PA_W-1:OFF_W];
  assign q_off = ld_pa_i[OFF_W-1:0];

  mlb_lookup #(.N_ENT(N_ENT), .LA_W(LA_W), .CORE_W(CORE_W)) u_lookup (
    .busy_i    (e_busy),
    .full_i    (e_full),
    .la_i      (e_la),
    .core_i    (e_core),
    .q_la_i    (q_la),
    .q_core_i  (ld_core_i),
    .hit_any_o (hit_any),
    .hit_full_o(hit_full),
    .hit_id_o  (hit_id),
    .free_any_o(free_any),
    .free_id_o (free_id)
  );

  assign is_miss  = ld_valid_i && !ld_fault_i && !cache_hit_i;
  assign do_alloc = is_miss && !hit_any && free_any;
  assign stall_o  = is_miss && !hit_any && !free_any;
  assign ld_ok    = ld_valid_i && !ld_fault_i && (cache_hit_i || (hit_any && hit_full));

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    mlb_entry #(.LA_W(LA_W), .CORE_W(CORE_W), .HOLD_CYC(HOLD_CYC)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (do_alloc && free_id == ID_W'(i)),
      .la_i       (q_la),
      .core_i     (ld_core_i),
      .off_i      (q_off),
      .sz_i       (ld_size_i),
      .fill_i     (fill_valid_i && fill_id_i == ID_W'(i)),
      .fill_line_i(fill_line_i),
      .busy_o     (e_busy[i]),
      .pend_o     (e_pend[i]),
      .full_o     (e_full[i]),
      .la_o       (e_la[i]),
      .core_o     (e_core[i]),
      .off_o      (e_off[i]),
      .sz_o       (e_sz[i]),
      .line_o     (e_line[i])
    );
  end

  // fill side: pick the named entry
  logic              fill_ok;
  logic [LA_W-1:0]   f_la;
  logic [CORE_W-1:0] f_core;
  logic [OFF_W-1:0]  f_off;
  logic [1:0]        f_sz;
  logic [LINE_W-1:0] hit_line, ld_src;

  always_comb begin
    fill_ok  = 1'b0;
    f_la     = '0;
    f_core   = '0;
    f_off    = '0;
    f_sz     = '0;
    hit_line = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (fill_id_i == ID_W'(i)) begin
        fill_ok = fill_valid_i && e_pend[i];
        f_la    = e_la[i];
        f_core  = e_core[i];
        f_off   = e_off[i];
        f_sz    = e_sz[i];
      end
      if (hit_id == ID_W'(i)) hit_line = e_line[i];
    end
  end

  // hit path and forwarding path share one selector
  assign ld_src = cache_hit_i ? cache_line_i : hit_line;

  logic [RSP_W-1:0] ld_bytes, f_bytes;

  mlb_byte_sel u_ld_sel (.line_i(ld_src),      .off_i(q_off), .sz_i(ld_size_i), .data_o(ld_bytes));
  mlb_byte_sel u_f_sel  (.line_i(fill_line_i), .off_i(f_off), .sz_i(f_sz),      .data_o(f_bytes));

  assign cwr_valid_o = fill_ok;
  assign cwr_la_o    = f_la;
  assign cwr_line_o  = fill_line_i;
  assign fwd_valid_o = fill_ok;
  assign fwd_core_o  = f_core;
  assign fwd_data_o  = fill_ok ? f_bytes : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_ok_o     <= 1'b0;
      rsp_data_o   <= '0;
      mreq_valid_o <= 1'b0;
      mreq_id_o    <= '0;
      mreq_la_o    <= '0;
    end else begin
      rsp_valid_o  <= ld_valid_i;
      rsp_ok_o     <= ld_ok;
      rsp_data_o   <= ld_ok ? ld_bytes : '0;
      mreq_valid_o <= do_alloc;
      if (do_alloc) begin
        mreq_id_o <= free_id;
        mreq_la_o <= q_la;
      end
    end
  end
endmodule

// File: rtl/mlb_chk.sv
module mlb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ld_valid_i,
  input logic        ld_fault_i,
  input logic        cache_hit_i,
  input logic        stall_o,
  input logic        rsp_valid_o,
  input logic        rsp_ok_o,
  input logic [63:0] rsp_data_o,
  input logic        mreq_valid_o,
  input logic        cwr_valid_o,
  input logic        fwd_valid_o
);
  // R2
  fault_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_fault_i |=> !mreq_valid_o && !rsp_ok_o);
  // R3
  hit_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && !ld_fault_i && cache_hit_i |=> rsp_ok_o && !mreq_valid_o);
  // R10
  zero_on_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ok_o |-> rsp_data_o == '0);
  // R9
  stall_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !mreq_valid_o && !rsp_ok_o);
  // R6
  fill_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr_valid_o == fwd_valid_o);
  // R4
  req_from_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o |-> $past(ld_valid_i) && !$past(ld_fault_i));
endmodule

bind miss_line_buf mlb_chk u_mlb_chk (.*);

// File: tb/tb_miss_line_buf.sv
`timescale 1ns/1ps
module tb_miss_line_buf;
  localparam int N = 4;
  localparam int PA_W = 32;
  localparam int HOLD = 4;
  localparam int LAW = PA_W - 6;

  logic clk_i = 0, rst_ni = 0;
  logic ld_valid_i = 0, ld_fault_i = 0, cache_hit_i = 0, fill_valid_i = 0;
  logic [PA_W-1:0] ld_pa_i = '0;
  logic [1:0] ld_size_i = '0, fill_id_i = '0, mreq_id_o;
  logic [0:0] ld_core_i = '0, fwd_core_o;
  logic [511:0] cache_line_i = '0, fill_line_i = '0, cwr_line_o;
  logic stall_o, rsp_valid_o, rsp_ok_o, mreq_valid_o, cwr_valid_o, fwd_valid_o;
  logic [63:0] rsp_data_o, fwd_data_o;
  logic [LAW-1:0] mreq_la_o, cwr_la_o;

  always #4 clk_i = ~clk_i;

  miss_line_buf #(.N_ENT(N), .PA_W(PA_W), .CORE_W(1), .HOLD_CYC(HOLD)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  int m_st[N], m_cnt[N];
  logic [LAW-1:0] m_la[N];
  bit m_core[N];
  int m_off[N], m_sz[N];
  logic [511:0] m_line[N];

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_bytes(logic [511:0] line, int off, int sz);
    logic [63:0] d = '0;
    logic [511:0] sh;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
    for (int k = 0; k < n; k++)
      if (off + k < 64) begin
        sh = line >> (8 * (off + k));
        d = d | (64'(sh[7:0]) << (8 * k));
      end
    return d;
  endfunction

  function automatic logic [511:0] rnd_line();
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[32*w +: 32] = $urandom;
    return l;
  endfunction

  task automatic step(bit lv, logic [31:0] pa, int sz, bit core, bit flt, bit ch,
                      logic [511:0] cl, bit fv, int fid, logic [511:0] fl, string tag);
    int hm, fr;
    bit e_stall, e_fill, e_ok, e_alloc;
    logic [63:0] e_data;
    logic [LAW-1:0] la;
    ld_valid_i = lv; ld_pa_i = pa; ld_size_i = 2'(sz); ld_core_i = core;
    ld_fault_i = flt; cache_hit_i = ch; cache_line_i = cl;
    fill_valid_i = fv; fill_id_i = 2'(fid); fill_line_i = fl;
    la = pa[31:6];
    hm = -1; fr = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_st[i] != 0 && m_la[i] == la && m_core[i] == core) hm = i;
      if (m_st[i] == 0) fr = i;
    end
    e_stall = lv && !flt && !ch && hm < 0 && fr < 0;
    e_alloc = lv && !flt && !ch && hm < 0 && fr >= 0;
    e_fill  = fv && m_st[fid] == 1;
    e_ok    = lv && !flt && (ch || (hm >= 0 && m_st[hm] == 2));
    e_data  = !e_ok ? 64'h0 : ch ? ref_bytes(cl, int'(pa[5:0]), sz)
                                 : ref_bytes(m_line[hm], int'(pa[5:0]), sz);
    #2;
    chk({tag, " R9 stall"}, 512'(stall_o), 512'(e_stall));
    chk({tag, " R6 cwr_valid"}, 512'(cwr_valid_o), 512'(e_fill));
    chk({tag, " R6 fwd_valid"}, 512'(fwd_valid_o), 512'(e_fill));
    if (e_fill) begin
      chk({tag, " R6 cwr_la"}, 512'(cwr_la_o), 512'(m_la[fid]));
      chk({tag, " R6 cwr_line"}, cwr_line_o, fl);
      chk({tag, " R6 fwd_core"}, 512'(fwd_core_o), 512'(m_core[fid]));
      chk({tag, " R7 fwd_data"}, 512'(fwd_data_o), 512'(ref_bytes(fl, m_off[fid], m_sz[fid])));
    end
    @(posedge clk_i);
    for (int i = 0; i < N; i++)
      if (m_st[i] == 2) begin
        if (m_cnt[i] == 1) m_st[i] = 0; else m_cnt[i]--;
      end
    if (e_fill) begin m_st[fid] = 2; m_cnt[fid] = HOLD; m_line[fid] = fl; end
    if (e_alloc) begin
      m_st[fr] = 1; m_la[fr] = la; m_core[fr] = core; m_off[fr] = int'(pa[5:0]); m_sz[fr] = sz;
    end
    #1;
    chk({tag, " R5 rsp_valid"}, 512'(rsp_valid_o), 512'(lv));
    if (lv) begin
      chk({tag, " R5 rsp_ok"}, 512'(rsp_ok_o), 512'(e_ok));
      chk({tag, " R10 rsp_data"}, 512'(rsp_data_o), 512'(e_data));
    end
    chk({tag, " R4 mreq_valid"}, 512'(mreq_valid_o), 512'(e_alloc));
    if (e_alloc) begin
      chk({tag, " R4 mreq_id"}, 512'(mreq_id_o), 512'(fr));
      chk({tag, " R4 mreq_la"}, 512'(mreq_la_o), 512'(la));
    end
    @(negedge clk_i);
  endtask

  task automatic ld(logic [31:0] pa, int sz, bit core, bit flt, bit ch, logic [511:0] cl, string tag);
    step(1, pa, sz, core, flt, ch, cl, 0, 0, '0, tag);
  endtask

  task automatic idle(string tag);
    step(0, '0, 0, 0, 0, 0, '0, 0, 0, '0, tag);
  endtask

  localparam logic [31:0] LA_A = 32'h0000_1000, LA_B = 32'h0000_2040,
                          LA_C = 32'h0000_3080, LA_D = 32'h0000_40C0, LA_E = 32'h0000_5000;

  initial begin
    logic [511:0] l1, l2;
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
    #3;
    chk("R1 rsp_valid", 512'(rsp_valid_o), 0);
    chk("R1 mreq_valid", 512'(mreq_valid_o), 0);
    chk("R1 stall", 512'(stall_o), 0);
    chk("R1 cwr_valid", 512'(cwr_valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    l1 = rnd_line(); l2 = rnd_line();
    // R3 / R7 cache hits at various offsets and sizes
    ld(LA_A + 0, 3, 0, 0, 1, l1, "R3");
    ld(LA_A + 13, 0, 0, 0, 1, l1, "R7");
    ld(LA_A + 30, 1, 1, 0, 1, l1, "R7");
    ld(LA_A + 60, 3, 0, 0, 1, l1, "R7 truncate");
    ld(LA_A + 63, 2, 0, 0, 1, l1, "R7 truncate");
    // R2 faulting loads
    ld(LA_A, 3, 0, 1, 1, l1, "R2 hit");
    ld(LA_A, 3, 0, 1, 0, l1, "R2 miss");
    // R4 allocate, R5 pending match and core distinction
    ld(LA_A + 8, 2, 0, 0, 0, '0, "R4");
    ld(LA_A + 16, 3, 0, 0, 0, '0, "R5 pend");
    ld(LA_A + 4, 1, 1, 0, 0, '0, "R5 core");
    ld(LA_B + 5, 3, 0, 0, 0, '0, "R4");
    ld(LA_C, 0, 1, 0, 0, '0, "R4");
    ld(LA_D, 3, 0, 0, 0, '0, "R9");
    // R6 fill entry 0, then again (ignored)
    step(0, '0, 0, 0, 0, 0, '0, 1, 0, l2, "R6 fill");
    step(0, '0, 0, 0, 0, 0, '0, 1, 0, l1, "R6 ignored");
    ld(LA_A + 40, 3, 0, 0, 0, '0, "R5 full");
    ld(LA_A + 40, 3, 1, 0, 0, '0, "R5 other core");
    ld(LA_A + 40, 3, 0, 1, 0, '0, "R2 full match");
    step(1, LA_E, 3, 0, 0, 0, '0, 1, 1, l1, "R6 fill with load");
    repeat (HOLD) idle("R8 wait");
    ld(LA_A + 40, 3, 0, 0, 0, '0, "R8 freed");
    // mixed stimulus
    for (int c = 0; c < 600; c++) begin
      logic [31:0] pa;
      pa = {20'h0, 6'($urandom_range(0, 5)), 6'($urandom)};
      step($urandom_range(0, 3) != 0, pa, $urandom_range(0, 3), 1'($urandom),
           $urandom_range(0, 9) == 0, $urandom_range(0, 4) == 0, rnd_line(),
           $urandom_range(0, 2) == 0, $urandom_range(0, 3), rnd_line(), "R5 mix");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule